// File: doc/BRIEF.md
# Two-Wire Bus Master with Automatic Stop

This block is a two-wire (I2C-style) bus master. Software supplies a 7-bit device address, a direction and, optionally, one internal address byte, and then pulses a start command. The master generates the start condition and shifts out the address byte with the direction bit in the least significant position. For a write it then streams data bytes from a one-entry transmit holding register. It samples the acknowledge on the ninth clock of every byte.

The write side needs no explicit end command. After each acknowledged byte the master checks the holding register. If a byte is waiting, it moves that byte into the shifter and sends it. If the register is empty, the master closes the transfer with a stop condition of its own accord. A transmit-ready output shows that the holding register can take another byte, and a DMA channel can use it directly as its request. A refused acknowledge aborts the transfer with a stop. A read transfer ends with a stop after the address acknowledge.

The bus lines are open-drain. The block asserts an output enable to pull a line low and releases it otherwise. The data line is read back through a synchronizer. The bit rate comes from a divider input. One tick lasts `scl_div_i + 1` clock cycles, and a bit takes four ticks: two with the clock line low and two with it released.

Top module: `i2cm_top`

## Requirements
- R1: After reset, tx_ready_o = 1, tx_done_o = 1, nack_o = 0, and neither line is pulled (scl_oe_o = 0, sda_oe_o = 0).
- R2: A start_i pulse while idle clears tx_done_o and nack_o in the following cycle. It then pulls the data line low while the clock line is released, and only after that pulls the clock line low.
- R3: The first byte on the bus is the device address, most significant bit first, followed by a direction bit: 0 = write, 1 = read.
- R4: Inside a byte, sda_oe_o changes only while scl_oe_o is 1 (clock line low). A data edge while the clock is released occurs only as a start or a stop.
- R5: On the ninth clock of each byte the master releases the data line and samples it. If the line is high, nack_o is set and stays set until the next accepted start.
- R6: After a refused acknowledge the master sends no further byte and takes nothing from the holding register. It generates a stop and sets tx_done_o.
- R7: When the internal-address enable is set at start, the byte iaddr_i is sent right after the acknowledged device address and before any data byte. Otherwise no such byte is sent.
- R8: After an acknowledged byte (other than a read address) a waiting holding-register byte is sent next. tx_ready_o returns to 1 in the cycle after that byte is moved into the shifter.
- R9: If the holding register is empty when a byte's acknowledge completes, the master generates a stop without any command. tx_done_o rises only once both lines are released after the stop.
- R10: A thr_wr_i pulse makes tx_ready_o 0 in the following cycle.
- R11: During a byte, the clock line is released for 2*(scl_div_i+1) cycles and pulled low for 2*(scl_div_i+1) cycles per bit.
- R12: In read mode the master stops after the address acknowledge and leaves a waiting holding-register byte in place (tx_ready_o stays 0).
- R13: A start_i pulse during a transfer is ignored. No second start is generated, and the bytes on the bus are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_div_i | input | DIV_W | Tick length minus one, in clock cycles |
| start_i | input | 1 | Start command pulse (ignored when busy) |
| rd_mode_i | input | 1 | Direction for the next transfer: 1 = read |
| dev_addr_i | input | BYTE_W-1 | 7-bit device address |
| iaddr_en_i | input | 1 | Insert an internal address byte |
| iaddr_i | input | BYTE_W | Internal address byte |
| thr_wr_i | input | 1 | Write pulse for the transmit holding register |
| thr_data_i | input | BYTE_W | Data for the holding register |
| tx_ready_o | output | 1 | Holding register can accept a byte (DMA request) |
| tx_done_o | output | 1 | Transfer finished, stop included |
| nack_o | output | 1 | Sticky refused-acknowledge flag |
| scl_oe_o | output | 1 | Pull the clock line low |
| sda_oe_o | output | 1 | Pull the data line low |
| sda_i | input | 1 | Data line level |

## Verification
The bench builds the block with DIV_W = 4 and SYNC_STAGES = 2. A short divider setting of 1 keeps whole multi-byte transfers to a few hundred cycles, and one run with setting 3 makes the high and low clock phases long enough to measure directly. The two synchronizer stages put the acknowledge sampling behind a realistic input delay. A bus-level responder in the bench decodes the start, stop and byte traffic and acknowledges selected bytes, so the refused-acknowledge cases can be reached on the address and on a data byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_BYTE  = 2'd2,
    SQ_STOP  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    BK_ADDR  = 2'd0,
    BK_IADDR = 2'd1,
    BK_DATA  = 2'd2
  } byte_kind_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b1;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];

endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = 1'b0;
    if (!run_i) begin
      cnt_d = div_i;
    end else if (cnt_q == '0) begin
      tick_o = 1'b1;
      cnt_d  = div_i;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2cm_hold.sv
module i2cm_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o
);

  logic [BYTE_W-1:0] data_q, data_d;
  logic              full_q, full_d;
  logic              data_en;

  assign data_en = wr_i;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (wr_i) begin
      data_d = data_i;
      full_d = 1'b1;
    end else if (take_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              rd_mode_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic              iaddr_en_i,
  input  logic [BYTE_W-1:0] iaddr_i,
  input  logic              hold_full_i,
  input  logic [BYTE_W-1:0] hold_data_i,
  input  logic              sda_in_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              in_byte_o,
  output logic              done_o,
  output logic              nack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);

  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  seq_st_e           st_q, st_d;
  byte_kind_e        kind_q, kind_d;
  logic [1:0]        ph_q, ph_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] ia_q, ia_d;
  logic              ack_q, ack_d;
  logic              rd_q, rd_d;
  logic              ien_q, ien_d;
  logic              done_q, done_d;
  logic              nack_q, nack_d;
  logic              scl_q, scl_d;
  logic              sda_q, sda_d;

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    ia_d   = ia_q;
    ack_d  = ack_q;
    rd_d   = rd_q;
    ien_d  = ien_q;
    done_d = done_q;
    nack_d = nack_q;
    scl_d  = scl_q;
    sda_d  = sda_q;
    take_o = 1'b0;

    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d   = SQ_START;
          ph_d   = 2'd0;
          bit_d  = '0;
          done_d = 1'b0;
          nack_d = 1'b0;
          rd_d   = rd_mode_i;
          ien_d  = iaddr_en_i;
          ia_d   = iaddr_i;
          sh_d   = {dev_addr_i, rd_mode_i};
          kind_d = BK_ADDR;
        end
      end

      SQ_START: begin
        if (tick_i) begin
          if (ph_q == 2'd0) begin
            sda_d = 1'b1;
            ph_d  = 2'd1;
          end else begin
            scl_d = 1'b1;
            ph_d  = 2'd0;
            st_d  = SQ_BYTE;
          end
        end
      end

      SQ_BYTE: begin
        if (tick_i) begin
          unique case (ph_q)
            2'd0: begin
              sda_d = (bit_q == ACK_SLOT) ? 1'b0 : ~sh_q[BYTE_W-1];
              ph_d  = 2'd1;
            end
            2'd1: begin
              scl_d = 1'b0;
              ph_d  = 2'd2;
            end
            2'd2: begin
              if (bit_q == ACK_SLOT) begin
                ack_d = ~sda_in_i;
                if (sda_in_i) nack_d = 1'b1;
              end
              ph_d = 2'd3;
            end
            default: begin
              scl_d = 1'b1;
              ph_d  = 2'd0;
              if (bit_q != ACK_SLOT) begin
                sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
                bit_d = bit_q + 1'b1;
              end else begin
                bit_d = '0;
                if (!ack_q) begin
                  st_d = SQ_STOP;
                end else if (kind_q == BK_ADDR && rd_q) begin
                  st_d = SQ_STOP;
                end else if (kind_q == BK_ADDR && ien_q) begin
                  sh_d   = ia_q;
                  kind_d = BK_IADDR;
                end else if (hold_full_i) begin
                  sh_d   = hold_data_i;
                  take_o = 1'b1;
                  kind_d = BK_DATA;
                end else begin
                  st_d = SQ_STOP;
                end
              end
            end
          endcase
        end
      end

      default: begin
        if (tick_i) begin
          ph_d = ph_q + 2'd1;
          unique case (ph_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: begin
              done_d = 1'b1;
              st_d   = SQ_IDLE;
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      kind_q <= BK_ADDR;
      ph_q   <= 2'd0;
      bit_q  <= '0;
      sh_q   <= '0;
      ia_q   <= '0;
      ack_q  <= 1'b0;
      rd_q   <= 1'b0;
      ien_q  <= 1'b0;
      done_q <= 1'b1;
      nack_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ia_q   <= ia_d;
      ack_q  <= ack_d;
      rd_q   <= rd_d;
      ien_q  <= ien_d;
      done_q <= done_d;
      nack_q <= nack_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
    end
  end

  assign busy_o    = (st_q != SQ_IDLE);
  assign in_byte_o = (st_q == SQ_BYTE);
  assign done_o    = done_q;
  assign nack_o    = nack_q;
  assign scl_oe_o  = scl_q;
  assign sda_oe_o  = sda_q;

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top #(
  parameter int BYTE_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  scl_div_i,
  input  logic              start_i,
  input  logic              rd_mode_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic              iaddr_en_i,
  input  logic [BYTE_W-1:0] iaddr_i,
  input  logic              thr_wr_i,
  input  logic [BYTE_W-1:0] thr_data_i,
  output logic              tx_ready_o,
  output logic              tx_done_o,
  output logic              nack_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);

  logic              sda_sync;
  logic              tick;
  logic              seq_busy;
  logic              seq_in_byte;
  logic              hold_take;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;

  i2cm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sda_i),
    .q_o   (sda_sync)
  );

  i2cm_tick #(.DIV_W(DIV_W)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (seq_busy),
    .div_i  (scl_div_i),
    .tick_o (tick)
  );

  i2cm_hold #(.BYTE_W(BYTE_W)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (thr_wr_i),
    .data_i (thr_data_i),
    .take_i (hold_take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  i2cm_seq #(.BYTE_W(BYTE_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .start_i     (start_i),
    .rd_mode_i   (rd_mode_i),
    .dev_addr_i  (dev_addr_i),
    .iaddr_en_i  (iaddr_en_i),
    .iaddr_i     (iaddr_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .sda_in_i    (sda_sync),
    .take_o      (hold_take),
    .busy_o      (seq_busy),
    .in_byte_o   (seq_in_byte),
    .done_o      (tx_done_o),
    .nack_o      (nack_o),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o)
  );

  assign tx_ready_o = ~hold_full;

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic thr_wr_i,
  input logic tx_ready_o,
  input logic tx_done_o,
  input logic nack_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy,
  input logic in_byte,
  input logic take
);

  // R10
  thr_wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_i |=> !tx_ready_o);

  // R2
  start_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (!tx_done_o && !nack_o));

  // R4
  data_stable_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && !scl_oe_o && !$past(scl_oe_o)) |-> $stable(sda_oe_o));

  // R5
  nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_o && !(start_i && !busy)) |=> nack_o);

  // R5
  nack_on_released_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_o) |-> (!sda_oe_o && !scl_oe_o));

  // R6
  no_take_after_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> !take);

  // R8
  ready_rise_from_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready_o) |-> $past(take));

  // R9
  done_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done_o) |-> (!scl_oe_o && !sda_oe_o));

endmodule

bind i2cm_top i2cm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .thr_wr_i   (thr_wr_i),
  .tx_ready_o (tx_ready_o),
  .tx_done_o  (tx_done_o),
  .nack_o     (nack_o),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy       (seq_busy),
  .in_byte    (seq_in_byte),
  .take       (hold_take)
);

// File: tb/test_i2cm_top.sv
`timescale 1ns/1ps
module test_i2cm_top;

  localparam int BYTE_W = 8;
  localparam int DIV_W  = 4;

  logic              clk;
  logic              rst_n;
  logic [DIV_W-1:0]  scl_div;
  logic              start;
  logic              rd_mode;
  logic [BYTE_W-2:0] dev_addr;
  logic              iaddr_en;
  logic [BYTE_W-1:0] iaddr;
  logic              thr_wr;
  logic [BYTE_W-1:0] thr_data;
  logic              tx_ready;
  logic              tx_done;
  logic              nack;
  logic              scl_oe;
  logic              sda_oe;
  logic              sda_line;

  int checks = 0;
  int fails  = 0;

  // bus responder state
  logic       slv_pull;
  logic       slv_clr;
  logic [7:0] ack_mask;
  int         slv_bit, slv_bytes, slv_starts, slv_stops;
  logic [7:0] slv_sh;
  logic [7:0] slv_log [8];
  logic       prev_scl, prev_sda;

  assign sda_line = ~(sda_oe | slv_pull);

  i2cm_top #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) i_i2cm_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_div_i  (scl_div),
    .start_i    (start),
    .rd_mode_i  (rd_mode),
    .dev_addr_i (dev_addr),
    .iaddr_en_i (iaddr_en),
    .iaddr_i    (iaddr),
    .thr_wr_i   (thr_wr),
    .thr_data_i (thr_data),
    .tx_ready_o (tx_ready),
    .tx_done_o  (tx_done),
    .nack_o     (nack),
    .scl_oe_o   (scl_oe),
    .sda_oe_o   (sda_oe),
    .sda_i      (sda_line)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    logic scl_now, sda_now;
    scl_now = ~scl_oe;
    sda_now = sda_line;
    if (slv_clr) begin
      slv_bit = 0; slv_bytes = 0; slv_starts = 0; slv_stops = 0;
      slv_sh = 8'h00; slv_pull = 1'b0;
      for (int i = 0; i < 8; i++) slv_log[i] = 8'h00;
    end else begin
      if (prev_scl && scl_now && prev_sda && !sda_now) begin
        slv_starts++;
        slv_bit = 0;
      end else if (prev_scl && scl_now && !prev_sda && sda_now) begin
        slv_stops++;
      end else if (!prev_scl && scl_now) begin
        if (slv_bit < 8) begin
          slv_sh = {slv_sh[6:0], sda_now};
          slv_bit++;
          if (slv_bit == 8 && slv_bytes < 8) slv_log[slv_bytes] = slv_sh;
        end else begin
          slv_bit = 0;
          slv_bytes++;
        end
      end else if (prev_scl && !scl_now) begin
        slv_pull = (slv_bit == 8 && slv_bytes < 8) ? ack_mask[slv_bytes] : 1'b0;
      end
    end
    prev_scl = scl_now;
    prev_sda = sda_now;
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; rd_mode = 1'b0; dev_addr = '0;
    iaddr_en = 1'b0; iaddr = '0; thr_wr = 1'b0; thr_data = '0;
    scl_div = 4'd1; ack_mask = 8'hFF; slv_clr = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    slv_clr = 1'b0;
    step();
  endtask

  task automatic write_thr(input logic [7:0] d);
    thr_wr = 1'b1; thr_data = d;
    step();
    thr_wr = 1'b0;
  endtask

  task automatic kick(input logic rd, input logic [6:0] a, input logic ien, input logic [7:0] ia);
    rd_mode = rd; dev_addr = a; iaddr_en = ien; iaddr = ia;
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (tx_done !== 1'b1 && n < 5000) begin step(); n++; end
    chk(tag, {31'd0, tx_done}, 32'd1);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (tx_ready !== 1'b1 && n < 5000) begin step(); n++; end
    chk(tag, {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 tx_ready", {31'd0, tx_ready}, 32'd1);
    chk("R1 tx_done", {31'd0, tx_done}, 32'd1);
    chk("R1 nack", {31'd0, nack}, 32'd0);
    chk("R1 lines", {30'd0, scl_oe, sda_oe}, 32'd0);
  endtask

  task automatic t_single_write();
    do_reset();
    write_thr(8'h3C);
    chk("R10 ready cleared", {31'd0, tx_ready}, 32'd0);
    kick(1'b0, 7'h50, 1'b0, 8'h00);
    chk("R2 done cleared", {31'd0, tx_done}, 32'd0);
    wait_done("R9 done after write");
    step();
    chk("R3 write address byte", {24'd0, slv_log[0]}, 32'hA0);
    chk("R8 data byte", {24'd0, slv_log[1]}, 32'h3C);
    chk("R9 byte count", slv_bytes, 32'd2);
    chk("R2 one start", slv_starts, 32'd1);
    chk("R9 auto stop", slv_stops, 32'd1);
    chk("R8 ready back", {31'd0, tx_ready}, 32'd1);
    chk("R5 no nack", {31'd0, nack}, 32'd0);
    chk("R9 lines free", {30'd0, scl_oe, sda_oe}, 32'd0);
  endtask

  task automatic t_addr_only();
    do_reset();
    kick(1'b0, 7'h11, 1'b0, 8'h00);
    wait_done("R9 done addr only");
    step();
    chk("R9 addr only bytes", slv_bytes, 32'd1);
    chk("R3 addr only byte", {24'd0, slv_log[0]}, 32'h22);
    chk("R9 addr only stop", slv_stops, 32'd1);
  endtask

  task automatic t_stream_iaddr();
    logic [7:0] d [3] = '{8'h81, 8'h42, 8'hE7};
    do_reset();
    write_thr(d[0]);
    kick(1'b0, 7'h68, 1'b1, 8'h5A);
    for (int i = 1; i < 3; i++) begin
      wait_ready("R8 ready rises on move");
      write_thr(d[i]);
    end
    wait_done("R9 done after stream");
    step();
    chk("R3 stream address", {24'd0, slv_log[0]}, 32'hD0);
    chk("R7 internal address", {24'd0, slv_log[1]}, 32'h5A);
    chk("R8 stream d0", {24'd0, slv_log[2]}, 32'h81);
    chk("R8 stream d1", {24'd0, slv_log[3]}, 32'h42);
    chk("R8 stream d2", {24'd0, slv_log[4]}, 32'hE7);
    chk("R9 stream count", slv_bytes, 32'd5);
    chk("R9 stream stop", slv_stops, 32'd1);
  endtask

  task automatic t_nack_addr();
    do_reset();
    ack_mask = 8'h00;
    write_thr(8'h99);
    kick(1'b0, 7'h7F, 1'b0, 8'h00);
    wait_done("R6 done after addr nack");
    step();
    chk("R5 nack set", {31'd0, nack}, 32'd1);
    chk("R6 one byte only", slv_bytes, 32'd1);
    chk("R6 stop after nack", slv_stops, 32'd1);
    chk("R6 holding kept", {31'd0, tx_ready}, 32'd0);
    repeat (20) step();
    chk("R5 nack sticky", {31'd0, nack}, 32'd1);
    ack_mask = 8'hFF;
    kick(1'b0, 7'h7F, 1'b0, 8'h00);
    chk("R2 nack cleared", {31'd0, nack}, 32'd0);
    wait_done("R9 done retry");
    step();
    chk("R8 retry consumed", {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_nack_data();
    do_reset();
    ack_mask = 8'h01;
    write_thr(8'h10);
    kick(1'b0, 7'h20, 1'b0, 8'h00);
    wait_ready("R8 first move");
    write_thr(8'h20);
    wait_done("R6 done after data nack");
    step();
    chk("R5 data nack", {31'd0, nack}, 32'd1);
    chk("R6 bytes after data nack", slv_bytes, 32'd2);
    chk("R6 second byte held", {31'd0, tx_ready}, 32'd0);
    chk("R6 stop count", slv_stops, 32'd1);
  endtask

  task automatic t_read();
    do_reset();
    write_thr(8'hAA);
    kick(1'b1, 7'h2B, 1'b1, 8'h33);
    wait_done("R12 done read");
    step();
    chk("R3 read address byte", {24'd0, slv_log[0]}, 32'h57);
    chk("R12 read one byte", slv_bytes, 32'd1);
    chk("R12 holding untouched", {31'd0, tx_ready}, 32'd0);
    chk("R12 read stop", slv_stops, 32'd1);
  endtask

  task automatic t_divider();
    int n;
    int hi = 0;
    int lo = 0;
    do_reset();
    scl_div = 4'd3;
    kick(1'b0, 7'h55, 1'b0, 8'h00);
    n = 0;
    while (scl_oe !== 1'b1 && n < 500) begin step(); n++; end
    n = 0;
    while (scl_oe !== 1'b0 && n < 500) begin step(); n++; end
    while (scl_oe === 1'b0 && hi < 500) begin step(); hi++; end
    while (scl_oe === 1'b1 && lo < 500) begin step(); lo++; end
    chk("R11 clock high cycles", hi, 32'd8);
    chk("R11 clock low cycles", lo, 32'd8);
    wait_done("R11 done");
  endtask

  task automatic t_busy_start();
    do_reset();
    write_thr(8'hC3);
    kick(1'b0, 7'h0F, 1'b0, 8'h00);
    repeat (30) step();
    kick(1'b1, 7'h71, 1'b1, 8'h44);
    wait_done("R13 done");
    step();
    chk("R13 single start", slv_starts, 32'd1);
    chk("R13 address kept", {24'd0, slv_log[0]}, 32'h1E);
    chk("R13 data kept", {24'd0, slv_log[1]}, 32'hC3);
    chk("R13 byte count", slv_bytes, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single_write();
    t_addr_only();
    t_stream_iaddr();
    t_nack_addr();
    t_nack_data();
    t_read();
    t_divider();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule